// File: doc/BRIEF.md
# Xon/Xoff Receive Character Matcher

This block watches the stream of characters coming out of a serial receiver and detects the software flow-control characters. It raises a pause level when the remote side asks the local transmitter to stop, and drops the level when the remote side allows it to continue. The transmit path uses the pause level as a gate. Once the character being shifted out has finished, the transmitter sends no further characters until the level falls.

The four comparison values are programmable: two stop characters and two resume characters. A mode input chooses how the stream is matched. In one-character mode a single stop or resume character is enough. In two-character mode the first and second programmed characters must arrive as consecutive received characters. While the block is paused it compares only against the resume characters, and while it is running it compares only against the stop characters.

A stop match sets a status flag, which stands for interrupt status bit 4. The interrupt request is that flag gated by the interrupt enable, which stands for interrupt-enable bit 5. A resume match clears both the flag and the pause.

Top module: `xon_xoff_matcher`

## Requirements
- R1: In one-character mode, with software flow control enabled and the block not paused, a valid character equal to `xoff1` raises `tx_pause` and `xoff_flag` from the next clock edge.
- R2: In two-character mode, a pause requires a valid `xoff1` followed by a valid `xoff2` as the very next valid character. Cycles in which `rx_valid` is low between the two characters do not break the sequence.
- R3: In two-character mode, if a valid first-character match is followed by a valid character that is not the second character, the partial match is dropped. That character is then checked again as a possible first character, so the sequence `xoff1`, `xoff1`, `xoff2` does pause.
- R4: While paused, a valid `xon1` (one-character mode), or a valid `xon1` followed by a valid `xon2` (two-character mode), clears `tx_pause` and `xoff_flag` from the next edge.
- R5: Resume characters received while not paused leave `tx_pause` and `xoff_flag` unchanged. Stop characters received while paused also leave both outputs unchanged.
- R6: `irq` is high exactly when `xoff_flag` is high and `irq_en` is high.
- R7: Reset, or `sw_fc_en` low at a clock edge, clears `tx_pause`, `xoff_flag` and any partial match.
- R8: Cycles in which `rx_valid` is low never change `tx_pause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_fc_en | input | 1 | Software flow-control enable |
| two_char | input | 1 | 1: two-character sequences, 0: single character |
| irq_en | input | 1 | Interrupt enable for the stop-match flag |
| xon1 | input | 8 | First resume character |
| xon2 | input | 8 | Second resume character |
| xoff1 | input | 8 | First stop character |
| xoff2 | input | 8 | Second stop character |
| rx_valid | input | 1 | Strobe: `rx_byte` holds a newly received character |
| rx_byte | input | 8 | Received character |
| tx_pause | output | 1 | Transmit pause level |
| xoff_flag | output | 1 | Stop-match status flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. A one-character stop match always pauses the block on the next edge. A non-matching character in one-character mode never starts a pause. Idle cycles never move the pause level. The flag is never set without a pause. Disabling flow control always clears the pause on the next edge. Behaviour that depends on what came before can only be shown by the bench's scenarios: broken two-character sequences, a failed second character being checked again as a first character, and resume or stop characters that are ignored in the wrong state. For these the bench runs a queue-based model and compares it with the block on every cycle.

// File: rtl/xon_xoff_matcher.sv
module xon_xoff_matcher #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_fc_en,
  input  logic         two_char,
  input  logic         irq_en,
  input  logic [W-1:0] xon1,
  input  logic [W-1:0] xon2,
  input  logic [W-1:0] xoff1,
  input  logic [W-1:0] xoff2,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         tx_pause,
  output logic         xoff_flag,
  output logic         irq
);

  logic pause_q, flag_q, armed_q;

  // While paused only the resume characters matter, otherwise only the stop characters.
  wire [W-1:0] want1 = pause_q ? xon1 : xoff1;
  wire [W-1:0] want2 = pause_q ? xon2 : xoff2;

  wire first_hit  = (rx_byte == want1);
  wire second_hit = armed_q && (rx_byte == want2);
  wire seq_hit    = rx_valid && (two_char ? second_hit : first_hit);

  always_ff @(posedge clk) begin
    if (!rst_n || !sw_fc_en) begin
      pause_q <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (seq_hit) begin
      pause_q <= !pause_q;
      flag_q  <= !pause_q;
      armed_q <= 1'b0;
    end else if (rx_valid) begin
      armed_q <= two_char && first_hit;
    end else if (!two_char) begin
      armed_q <= 1'b0;
    end
  end

  assign tx_pause  = pause_q;
  assign xoff_flag = flag_q;
  assign irq       = flag_q && irq_en;

  assert_single_xoff_pauses_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fc_en && !two_char && rx_valid && !tx_pause && rx_byte == xoff1 |=> tx_pause && xoff_flag);

  assert_no_stray_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fc_en && !two_char && rx_valid && !tx_pause && rx_byte != xoff1 |=> !tx_pause);

  assert_idle_holds_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fc_en && !rx_valid |=> $stable(tx_pause));

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_fc_en |=> !tx_pause && !xoff_flag);

  assert_flag_needs_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_flag |-> tx_pause);

endmodule

// File: tb/tb_xon_xoff_matcher.sv
module tb_xon_xoff_matcher;
  logic clk = 0, rst_n = 0, sw_fc_en = 0, two_char = 0, irq_en = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h12, xoff1 = 8'h13, xoff2 = 8'h14;
  logic rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic tx_pause, xoff_flag, irq;

  int compared = 0, mismatched = 0;
  string phase = "R7";

  bit m_pause = 0, m_flag = 0;
  logic [7:0] hist[$];

  always #2 clk = ~clk;

  xon_xoff_matcher dut (.clk, .rst_n, .sw_fc_en, .two_char, .irq_en, .xon1, .xon2,
    .xoff1, .xoff2, .rx_valid, .rx_byte, .tx_pause, .xoff_flag, .irq);

  always @(posedge clk) begin
    if (!rst_n || !sw_fc_en) begin
      m_pause = 0; m_flag = 0; hist.delete();
    end else begin
      if (rx_valid) begin
        logic [7:0] c1, c2;
        bit hit;
        c1 = m_pause ? xon1 : xoff1;
        c2 = m_pause ? xon2 : xoff2;
        hist.push_back(rx_byte);
        if (two_char)
          hit = hist.size() >= 2 && hist[hist.size()-2] == c1 && hist[hist.size()-1] == c2;
        else
          hit = (rx_byte == c1);
        if (hit) begin
          m_pause = !m_pause; m_flag = m_pause; hist.delete();
        end
        if (hist.size() > 2) void'(hist.pop_front());
      end
      if (!two_char) hist.delete();
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(phase, tx_pause, m_pause, "tx_pause");
    chk(phase, xoff_flag, m_flag, "xoff_flag");
    chk("R6", irq, m_flag && irq_en, "irq");
  end

  task automatic send(logic [7:0] b);
    @(posedge clk); #1; rx_valid = 1; rx_byte = b;
    @(posedge clk); #1; rx_valid = 0; rx_byte = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_now(string tag, logic p, logic f);
    @(negedge clk);
    chk(tag, tx_pause, p, "directed tx_pause");
    chk(tag, xoff_flag, f, "directed xoff_flag");
  endtask

  initial begin
    #40000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3); #1; rst_n = 1;
    expect_now("R7", 0, 0);
    sw_fc_en = 1; irq_en = 1;
    phase = "R5"; send(8'h11); send(8'h41); expect_now("R5", 0, 0);
    phase = "R1"; send(8'h13); expect_now("R1", 1, 1);
    phase = "R6"; @(posedge clk); #1 irq_en = 0; idle(2); #1 irq_en = 1; idle(1);
    phase = "R5"; send(8'h13); expect_now("R5", 1, 1);
    phase = "R8"; idle(5); expect_now("R8", 1, 1);
    phase = "R4"; send(8'h11); expect_now("R4", 0, 0);
    two_char = 1;
    phase = "R2"; send(8'h13); idle(3); expect_now("R2", 0, 0); send(8'h14); expect_now("R2", 1, 1);
    phase = "R4"; send(8'h11); send(8'h20); send(8'h12); expect_now("R4", 1, 1);
    send(8'h11); send(8'h12); expect_now("R4", 0, 0);
    phase = "R3"; send(8'h13); send(8'h55); send(8'h14); expect_now("R3", 0, 0);
    send(8'h13); send(8'h13); send(8'h14); expect_now("R3", 1, 1);
    phase = "R7"; @(posedge clk); #1 sw_fc_en = 0; idle(1); expect_now("R7", 0, 0);
    #1 sw_fc_en = 1;
    send(8'h13); @(posedge clk); #1 sw_fc_en = 0; idle(1); #1 sw_fc_en = 1;
    send(8'h14); expect_now("R7", 0, 0);
    phase = "R3";
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (i % 500 == 0) two_char = ~two_char;
      rx_valid = ($urandom % 3) != 0;
      rx_byte = 8'h11 + 8'($urandom % 5);
      irq_en = ($urandom % 4) != 0;
    end
    @(posedge clk); #1 rx_valid = 0;
    idle(2);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule